// File: doc/BRIEF.md
# Debug Exit Context Restore Unit

This unit builds the processor context that is loaded when a debugger leaves halted debug mode with a resume-and-exit command. It takes the context saved at debug entry: program counter, instruction word, a PC-invalid flag, a 2-bit word offset that records pipeline skid, the instruction status bits and the internal state bits. From these it produces the program counter to restore, the instruction to inject, the fetch address that follows it, and the control bits to reload. It also flags whether debug mode will be entered again at once.

There are three paths. If the saved PC was marked invalid because an exception vector fetch faulted, a recovery PC and instruction supplied by the host replace the saved pair. Otherwise, if the offset is non-zero, the PC is backed up by the offset in words and a no-op is injected in place of the saved instruction. If the offset is zero, the saved pair is returned unchanged. In that last case the host may ask for the breakpoint request status bits to be cleared. If any of them stays set, the unit reports that debug mode will be re-entered before any instruction executes. A single-cycle `go` strobe registers the results, and `done` pulses in the following cycle.

Top module: `dbg_exit_restore`

## Requirements
- R1: While `rst_n` is low, and in the cycle after reset is released, `done`, `reenter` and `nop_inj` are 0, and `pc_out`, `insn_out`, `fetch_pc`, `stat_out` and `state_out` are all zero.
- R2: `go` high at a rising edge registers all outputs at that edge, and `done` is then high for exactly one cycle. While `go` is low, every data output keeps its value.
- R3: With `pc_inv`=1, `pc_out` equals `rcv_pc` and `insn_out` equals `rcv_insn`, whatever `pc_ofst` is. `stat_out` is all zero and `nop_inj` is 0.
- R4: With `pc_inv`=0, `pc_out` equals `pc_saved` minus 4 times `pc_ofst`, modulo 2^32.
- R5: With `pc_inv`=0 and `pc_ofst` non-zero, `insn_out` is the no-op 32'h60000000 and `nop_inj` is 1.
- R6: With `pc_inv`=0 and `pc_ofst` zero, `insn_out` equals `insn_saved` and `nop_inj` is 0.
- R7: `fetch_pc` equals `pc_out` plus 4, modulo 2^32.
- R8: With `pc_inv`=0 and `pc_ofst` non-zero, `stat_out` is all zero. This includes bit 7, the instruction-type bit.
- R9: `state_out` equals `state_saved` on every path.
- R10: With `pc_inv`=0 and `pc_ofst` zero, `stat_out` equals `stat_saved`, except that bits 5 to 2 are forced to 0 when `brk_clr` is 1.
- R11: `reenter` is 1 exactly when any of `stat_out` bits 5 to 2 is 1.
- R12: `nop_inj` is 1 exactly when the injected word is the substituted no-op. The debug event logic uses it to treat the no-op as an executed instruction, so that address-compare events are raised on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Single-cycle strobe that registers the restored context |
| pc_inv | input | 1 | PC-invalid flag captured at debug entry |
| pc_ofst | input | 2 | Pipeline skid offset, in words |
| pc_saved | input | 32 | PC saved at debug entry |
| insn_saved | input | 32 | Instruction word saved at debug entry |
| stat_saved | input | 8 | Saved instruction status bits |
| state_saved | input | 8 | Saved internal state bits |
| brk_clr | input | 1 | Clear breakpoint request bits 5..2 on the unadjusted path |
| rcv_pc | input | 32 | Host recovery PC for a faulted vector fetch |
| rcv_insn | input | 32 | Host recovery instruction for a faulted vector fetch |
| done | output | 1 | One-cycle pulse: restored context valid |
| pc_out | output | 32 | PC to restore |
| insn_out | output | 32 | Instruction to inject |
| fetch_pc | output | 32 | Fetch address after the injected instruction |
| stat_out | output | 8 | Instruction status bits to reload |
| state_out | output | 8 | Internal state bits to reload |
| reenter | output | 1 | Debug mode is re-entered before execution |
| nop_inj | output | 1 | Injected word is the substituted no-op |

## Verification
The bench covers each of the three paths. A unit that lets the offset leak into the faulted-fetch path would return a backed-up recovery PC. A unit that subtracts the offset in bytes instead of words would be off by a factor of four. A PC of 4 with offset 3, and a PC near the top of the address space, exercise wrap-around in the subtraction and in `fetch_pc`; dropping the carry there corrupts the high bits. Status patterns with breakpoint bits set are checked with and without `brk_clr`, on both the adjusted and unadjusted paths. A unit that keeps the type bit after adjustment, or that ORs the wrong bit range into `reenter`, shows up as a wrong status word or a spurious re-entry. Idle cycles with changing inputs confirm that nothing moves without `go`.

// File: rtl/dbg_exit_pkg.sv
package dbg_exit_pkg;
   typedef enum logic [1:0] {
      PATH_ORIG = 2'd0,
      PATH_ADJ  = 2'd1,
      PATH_RCV  = 2'd2
   } path_e;
endpackage

// File: rtl/dbg_exit_path_sel.sv
module dbg_exit_path_sel
   import dbg_exit_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int INSN_W   = 32,
   parameter int OFST_W   = 2,
   parameter int WORD_LSB = 2,
   parameter logic [INSN_W-1:0] NOP_INSN = 32'h6000_0000
) (
   input  logic              pc_inv,
   input  logic [OFST_W-1:0] pc_ofst,
   input  logic [ADDR_W-1:0] pc_saved,
   input  logic [INSN_W-1:0] insn_saved,
   input  logic [ADDR_W-1:0] rcv_pc,
   input  logic [INSN_W-1:0] rcv_insn,
   output path_e             path,
   output logic [ADDR_W-1:0] pc_next,
   output logic [INSN_W-1:0] insn_next
);
   logic [ADDR_W-1:0] skid_bytes;

   assign skid_bytes = ADDR_W'(pc_ofst) << WORD_LSB;

   always_comb begin
      if (pc_inv) begin
         path      = PATH_RCV;
         pc_next   = rcv_pc;
         insn_next = rcv_insn;
      end else if (pc_ofst != '0) begin
         path      = PATH_ADJ;
         pc_next   = pc_saved - skid_bytes;
         insn_next = NOP_INSN;
      end else begin
         path      = PATH_ORIG;
         pc_next   = pc_saved;
         insn_next = insn_saved;
      end
   end
endmodule

// File: rtl/dbg_exit_ctl_fix.sv
module dbg_exit_ctl_fix
   import dbg_exit_pkg::*;
#(
   parameter int STAT_W  = 8,
   parameter int STATE_W = 8,
   parameter int BRK_LO  = 2,
   parameter int BRK_HI  = 5
) (
   input  path_e              path,
   input  logic               brk_clr,
   input  logic [STAT_W-1:0]  stat_saved,
   input  logic [STATE_W-1:0] state_saved,
   output logic [STAT_W-1:0]  stat_next,
   output logic [STATE_W-1:0] state_next,
   output logic               reenter_next
);
   logic [STAT_W-1:0] brk_mask;
   logic [STAT_W-1:0] kept;

   for (genvar i = 0; i < STAT_W; i++) begin : g_mask
      if (i >= BRK_LO && i <= BRK_HI) begin : g_brk
         assign brk_mask[i] = 1'b1;
      end else begin : g_other
         assign brk_mask[i] = 1'b0;
      end
   end

   assign kept = brk_clr ? (stat_saved & ~brk_mask) : stat_saved;

   always_comb begin
      case (path)
         PATH_ORIG: stat_next = kept;
         default:   stat_next = '0;
      endcase
   end

   assign state_next   = state_saved;
   assign reenter_next = |(stat_next & brk_mask);
endmodule

// File: rtl/dbg_exit_restore.sv
module dbg_exit_restore
   import dbg_exit_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int INSN_W   = 32,
   parameter int OFST_W   = 2,
   parameter int WORD_LSB = 2,
   parameter int STAT_W   = 8,
   parameter int STATE_W  = 8,
   parameter int BRK_LO   = 2,
   parameter int BRK_HI   = 5,
   parameter logic [INSN_W-1:0] NOP_INSN = 32'h6000_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic               pc_inv,
   input  logic [OFST_W-1:0]  pc_ofst,
   input  logic [ADDR_W-1:0]  pc_saved,
   input  logic [INSN_W-1:0]  insn_saved,
   input  logic [STAT_W-1:0]  stat_saved,
   input  logic [STATE_W-1:0] state_saved,
   input  logic               brk_clr,
   input  logic [ADDR_W-1:0]  rcv_pc,
   input  logic [INSN_W-1:0]  rcv_insn,
   output logic               done,
   output logic [ADDR_W-1:0]  pc_out,
   output logic [INSN_W-1:0]  insn_out,
   output logic [ADDR_W-1:0]  fetch_pc,
   output logic [STAT_W-1:0]  stat_out,
   output logic [STATE_W-1:0] state_out,
   output logic               reenter,
   output logic               nop_inj
);
   localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(1) << WORD_LSB;

   if (BRK_HI >= STAT_W || BRK_LO > BRK_HI || BRK_LO < 0) begin : g_bad_brk
      $error("breakpoint status range outside status width");
   end
   if (OFST_W < 1 || OFST_W + WORD_LSB > ADDR_W) begin : g_bad_ofst
      $error("offset field does not fit the address width");
   end

   path_e              path;
   logic [ADDR_W-1:0]  pc_next;
   logic [INSN_W-1:0]  insn_next;
   logic [STAT_W-1:0]  stat_next;
   logic [STATE_W-1:0] state_next;
   logic               reenter_next;

   dbg_exit_path_sel #(
      .ADDR_W(ADDR_W), .INSN_W(INSN_W), .OFST_W(OFST_W),
      .WORD_LSB(WORD_LSB), .NOP_INSN(NOP_INSN)
   ) u_path (
      .pc_inv(pc_inv), .pc_ofst(pc_ofst), .pc_saved(pc_saved),
      .insn_saved(insn_saved), .rcv_pc(rcv_pc), .rcv_insn(rcv_insn),
      .path(path), .pc_next(pc_next), .insn_next(insn_next)
   );

   dbg_exit_ctl_fix #(
      .STAT_W(STAT_W), .STATE_W(STATE_W), .BRK_LO(BRK_LO), .BRK_HI(BRK_HI)
   ) u_ctl (
      .path(path), .brk_clr(brk_clr), .stat_saved(stat_saved),
      .state_saved(state_saved), .stat_next(stat_next),
      .state_next(state_next), .reenter_next(reenter_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done      <= 1'b0;
         pc_out    <= '0;
         insn_out  <= '0;
         fetch_pc  <= '0;
         stat_out  <= '0;
         state_out <= '0;
         reenter   <= 1'b0;
         nop_inj   <= 1'b0;
      end else begin
         done <= go;
         if (go) begin
            pc_out    <= pc_next;
            insn_out  <= insn_next;
            fetch_pc  <= pc_next + INSN_BYTES;
            stat_out  <= stat_next;
            state_out <= state_next;
            reenter   <= reenter_next;
            nop_inj   <= (path == PATH_ADJ);
         end
      end
   end
endmodule

// File: rtl/dbg_exit_restore_chk.sv
module dbg_exit_restore_chk #(
   parameter int ADDR_W   = 32,
   parameter int INSN_W   = 32,
   parameter int OFST_W   = 2,
   parameter int WORD_LSB = 2,
   parameter int STAT_W   = 8,
   parameter int STATE_W  = 8,
   parameter int BRK_LO   = 2,
   parameter int BRK_HI   = 5,
   parameter logic [INSN_W-1:0] NOP_INSN = 32'h6000_0000
) (
   input logic               clk,
   input logic               rst_n,
   input logic               go,
   input logic               pc_inv,
   input logic [OFST_W-1:0]  pc_ofst,
   input logic [ADDR_W-1:0]  pc_saved,
   input logic [INSN_W-1:0]  insn_saved,
   input logic [STAT_W-1:0]  stat_saved,
   input logic [STATE_W-1:0] state_saved,
   input logic               brk_clr,
   input logic [ADDR_W-1:0]  rcv_pc,
   input logic [INSN_W-1:0]  rcv_insn,
   input logic               done,
   input logic [ADDR_W-1:0]  pc_out,
   input logic [INSN_W-1:0]  insn_out,
   input logic [ADDR_W-1:0]  fetch_pc,
   input logic [STAT_W-1:0]  stat_out,
   input logic [STATE_W-1:0] state_out,
   input logic               reenter,
   input logic               nop_inj
);
   logic [STAT_W-1:0] brk_bits;
   always_comb begin
      brk_bits = '0;
      for (int i = BRK_LO; i <= BRK_HI; i++) brk_bits[i] = 1'b1;
   end

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> done);
   p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> !done);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> $stable(pc_out) && $stable(insn_out) && $stable(stat_out)
              && $stable(state_out) && $stable(reenter));
   p_recover_r3: assert property (@(posedge clk) disable iff (!rst_n)
      go && pc_inv |=> pc_out == $past(rcv_pc) && insn_out == $past(rcv_insn)
                       && stat_out == '0 && !nop_inj);
   p_backup_r4: assert property (@(posedge clk) disable iff (!rst_n)
      go && !pc_inv |=>
         pc_out == $past(pc_saved) - (ADDR_W'($past(pc_ofst)) << WORD_LSB));
   p_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      go && !pc_inv && pc_ofst != '0 |=> insn_out == NOP_INSN && nop_inj);
   p_orig_r6: assert property (@(posedge clk) disable iff (!rst_n)
      go && !pc_inv && pc_ofst == '0 |=> insn_out == $past(insn_saved) && !nop_inj);
   p_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> fetch_pc == pc_out + (ADDR_W'(1) << WORD_LSB));
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      go && !pc_inv && pc_ofst != '0 |=> stat_out == '0);
   p_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> state_out == $past(state_saved));
   p_reenter_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> reenter == ((stat_out & brk_bits) != '0));
endmodule

bind dbg_exit_restore dbg_exit_restore_chk #(
   .ADDR_W(ADDR_W), .INSN_W(INSN_W), .OFST_W(OFST_W), .WORD_LSB(WORD_LSB),
   .STAT_W(STAT_W), .STATE_W(STATE_W), .BRK_LO(BRK_LO), .BRK_HI(BRK_HI),
   .NOP_INSN(NOP_INSN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .go(go), .pc_inv(pc_inv), .pc_ofst(pc_ofst),
   .pc_saved(pc_saved), .insn_saved(insn_saved), .stat_saved(stat_saved),
   .state_saved(state_saved), .brk_clr(brk_clr), .rcv_pc(rcv_pc),
   .rcv_insn(rcv_insn), .done(done), .pc_out(pc_out), .insn_out(insn_out),
   .fetch_pc(fetch_pc), .stat_out(stat_out), .state_out(state_out),
   .reenter(reenter), .nop_inj(nop_inj)
);

// File: tb/dbg_exit_restore_test.sv
`timescale 1ns/1ps
module dbg_exit_restore_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go = 1'b0;
   logic        pc_inv = 1'b0;
   logic [1:0]  pc_ofst = '0;
   logic [31:0] pc_saved = '0;
   logic [31:0] insn_saved = '0;
   logic [7:0]  stat_saved = '0;
   logic [7:0]  state_saved = '0;
   logic        brk_clr = 1'b0;
   logic [31:0] rcv_pc = '0;
   logic [31:0] rcv_insn = '0;
   logic        done;
   logic [31:0] pc_out;
   logic [31:0] insn_out;
   logic [31:0] fetch_pc;
   logic [7:0]  stat_out;
   logic [7:0]  state_out;
   logic        reenter;
   logic        nop_inj;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   dbg_exit_restore uut (
      .clk(clk), .rst_n(rst_n), .go(go), .pc_inv(pc_inv), .pc_ofst(pc_ofst),
      .pc_saved(pc_saved), .insn_saved(insn_saved), .stat_saved(stat_saved),
      .state_saved(state_saved), .brk_clr(brk_clr), .rcv_pc(rcv_pc),
      .rcv_insn(rcv_insn), .done(done), .pc_out(pc_out), .insn_out(insn_out),
      .fetch_pc(fetch_pc), .stat_out(stat_out), .state_out(state_out),
      .reenter(reenter), .nop_inj(nop_inj)
   );

   typedef struct packed {
      logic        inv;
      logic [1:0]  ofst;
      logic        bclr;
      logic [31:0] pc;
      logic [31:0] insn;
      logic [7:0]  stat;
      logic [7:0]  state;
      logic [31:0] rpc;
      logic [31:0] rinsn;
      logic [31:0] e_pc;
      logic [31:0] e_insn;
      logic [7:0]  e_stat;
      logic        e_re;
      logic        e_nop;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t TBL [NVEC] = '{
      '{1'b0, 2'd0, 1'b0, 32'h0000_1000, 32'h7C08_02A6, 8'h84, 8'h5A, 32'h0, 32'h0,
        32'h0000_1000, 32'h7C08_02A6, 8'h84, 1'b1, 1'b0},
      '{1'b0, 2'd1, 1'b0, 32'h0000_2004, 32'h1111_1111, 8'hFF, 8'hA5, 32'h0, 32'h0,
        32'h0000_2000, 32'h6000_0000, 8'h00, 1'b0, 1'b1},
      '{1'b0, 2'd2, 1'b0, 32'h0000_3010, 32'h1212_1212, 8'h3C, 8'h01, 32'h0, 32'h0,
        32'h0000_3008, 32'h6000_0000, 8'h00, 1'b0, 1'b1},
      '{1'b0, 2'd3, 1'b0, 32'h0000_0004, 32'h1313_1313, 8'h80, 8'h77, 32'h0, 32'h0,
        32'hFFFF_FFF8, 32'h6000_0000, 8'h00, 1'b0, 1'b1},
      '{1'b1, 2'd3, 1'b0, 32'hDEAD_0000, 32'h2222_2222, 8'hFF, 8'h3C, 32'h0000_0700, 32'h4800_0000,
        32'h0000_0700, 32'h4800_0000, 8'h00, 1'b0, 1'b0},
      '{1'b0, 2'd0, 1'b1, 32'h0000_ABCC, 32'h3333_3333, 8'hFF, 8'hC3, 32'h0, 32'h0,
        32'h0000_ABCC, 32'h3333_3333, 8'hC3, 1'b0, 1'b0},
      '{1'b0, 2'd0, 1'b0, 32'hFFFF_FFFC, 32'h4444_4444, 8'h20, 8'h0F, 32'h0, 32'h0,
        32'hFFFF_FFFC, 32'h4444_4444, 8'h20, 1'b1, 1'b0},
      '{1'b0, 2'd0, 1'b0, 32'h0000_0100, 32'h5555_5555, 8'hC3, 8'hF0, 32'h0, 32'h0,
        32'h0000_0100, 32'h5555_5555, 8'hC3, 1'b0, 1'b0},
      '{1'b1, 2'd0, 1'b0, 32'h0000_0200, 32'h7777_7777, 8'h20, 8'h99, 32'h0000_0500, 32'h6666_6666,
        32'h0000_0500, 32'h6666_6666, 8'h00, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      pc_inv = v.inv; pc_ofst = v.ofst; brk_clr = v.bclr;
      pc_saved = v.pc; insn_saved = v.insn; stat_saved = v.stat;
      state_saved = v.state; rcv_pc = v.rpc; rcv_insn = v.rinsn;
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
   endtask

   initial begin : watchdog
      #200000;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [31:0] h_pc, h_insn;
      logic [7:0]  h_stat;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1", "done in reset", 32'(done), 32'h0);
      chk("R1", "pc_out in reset", pc_out, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "done after reset", 32'(done), 32'h0);
      chk("R1", "insn_out after reset", insn_out, 32'h0);
      chk("R1", "fetch_pc after reset", fetch_pc, 32'h0);
      chk("R1", "stat/state after reset", {16'h0, stat_out, state_out}, 32'h0);
      chk("R1", "reenter/nop after reset", {30'h0, reenter, nop_inj}, 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         apply(TBL[i]);
         chk("R2", "done pulse", 32'(done), 32'h1);
         chk(TBL[i].inv ? "R3" : "R4", "pc_out", pc_out, TBL[i].e_pc);
         chk(TBL[i].inv ? "R3" : (TBL[i].ofst != 0 ? "R5" : "R6"),
             "insn_out", insn_out, TBL[i].e_insn);
         chk("R7", "fetch_pc", fetch_pc, TBL[i].e_pc + 32'd4);
         chk(TBL[i].inv ? "R3" : (TBL[i].ofst != 0 ? "R8" : "R10"),
             "stat_out", 32'(stat_out), 32'(TBL[i].e_stat));
         chk("R9", "state_out", 32'(state_out), 32'(TBL[i].state));
         chk("R11", "reenter", 32'(reenter), 32'(TBL[i].e_re));
         chk("R12", "nop_inj", 32'(nop_inj), 32'(TBL[i].e_nop));
      end

      // R2: done drops after one cycle, outputs hold while inputs change
      h_pc = pc_out; h_insn = insn_out; h_stat = stat_out;
      pc_inv = 1'b0; pc_ofst = 2'd2; pc_saved = 32'h1234_5678;
      insn_saved = 32'h0BAD_0BAD; stat_saved = 8'h3C;
      @(negedge clk);
      chk("R2", "done single cycle", 32'(done), 32'h0);
      @(negedge clk);
      chk("R2", "pc_out held", pc_out, h_pc);
      chk("R2", "insn_out held", insn_out, h_insn);
      chk("R2", "stat_out held", 32'(stat_out), 32'(h_stat));

      // R10 and R11: one breakpoint bit kept at the boundary bit 2, other bits outside
      apply('{1'b0, 2'd0, 1'b0, 32'h0000_0040, 32'h0101_0101, 8'h04, 8'h00, 32'h0, 32'h0,
              32'h0, 32'h0, 8'h0, 1'b0, 1'b0});
      chk("R10", "stat bit2 kept", 32'(stat_out), 32'h04);
      chk("R11", "reenter bit2", 32'(reenter), 32'h1);
      apply('{1'b0, 2'd0, 1'b0, 32'h0000_0040, 32'h0101_0101, 8'h42, 8'h00, 32'h0, 32'h0,
              32'h0, 32'h0, 8'h0, 1'b0, 1'b0});
      chk("R11", "no reenter bits 1,6", 32'(reenter), 32'h0);

      // R12 with back-to-back strobes: nop flag follows each strobe
      @(negedge clk);
      pc_inv = 1'b0; pc_ofst = 2'd1; pc_saved = 32'h0000_0808; go = 1'b1;
      @(negedge clk);
      chk("R12", "nop_inj first", 32'(nop_inj), 32'h1);
      pc_ofst = 2'd0;
      @(negedge clk);
      go = 1'b0;
      chk("R12", "nop_inj second", 32'(nop_inj), 32'h0);
      chk("R6", "pc second", pc_out, 32'h0000_0808);
      chk("R2", "done held by back-to-back", 32'(done), 32'h1);

      // R1: reset in mid-operation clears everything
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "pc_out after re-reset", pc_out, 32'h0);
      chk("R1", "done after re-reset", 32'(done), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule